// File: doc/BRIEF.md
# Prioritised Set/Clear Interrupt Controller

This block keeps two 15-bit registers, one of enable bits and one of request bits. A processor writes either of them through a 16-bit bus port. On that port, data bit 15 chooses whether the other ones in the word set or clear the matching register bits. Peripherals post requests with single-cycle pulses. These arrive on a generic 14-bit pulse vector, on two timer-chip interrupt inputs and on a line-wrap strobe that marks the start of each field.

The controller folds the pending, enabled requests into a 3-bit processor interrupt level from 0 to 6. A master enable bit gates the whole output. Software reads either register back through the same port and clears a request by writing it with bit 15 low.

Request bit meanings:
- 0: transmit-empty
- 1: disk-block
- 2: software
- 3: ports/timers
- 4: copper
- 5: vertical-blank
- 6: blitter
- 7 to 10: audio channels 0 to 3
- 11: receive-full
- 12: disk-sync
- 13: external

Bit 14 of the request register is storage only. Bit 14 of the enable register is the master enable.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset both registers read back as zero and `irq_level` is 0.
- R2: A write with `wr_data[15]`=1 sets every register bit whose `wr_data` bit (14:0) is 1 and leaves the other bits unchanged.
- R3: A write with `wr_data[15]`=0 clears every register bit whose `wr_data` bit (14:0) is 1 and leaves the other bits unchanged.
- R4: `wr_sel`=0 selects the enable register and `wr_sel`=1 selects the request register. A write never changes the register it does not select.
- R5: `irq_level` is 0 when enable bit 14 is clear, or when (enable AND request) has no bit set in positions 13:0. Request bit 14 never raises the level.
- R6: Otherwise the level is taken from the highest group with a pending enabled bit:
  - 6: bit 13
  - 5: bits 11 or 12
  - 4: bits 7 to 10
  - 3: bits 4, 5 or 6
  - 2: bit 3
  - 1: bits 0, 1 or 2
- R7: A pulse on `src_pulse[i]` sets request bit i. A pulse on `timer_a_pulse` sets bit 3 and a pulse on `timer_b_pulse` sets bit 13. Pulses only ever set bits.
- R8: A pulse on `line_wrap` sets request bit 5, the vertical-blank request.
- R9: When a pulse and a bus clear hit the same request bit in the same cycle, the bit ends up set.
- R10: `irq_level` is registered. It still shows the old value in the cycle a write or pulse is presented and shows the new value from the next clock edge on, the same edge at which the registers change.
- R11: `rd_data` returns the enable register when `rd_sel`=0 and the request register when `rd_sel`=1, each in bits 14:0, with bit 15 always reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_sel | input | 1 | Write target: 0 enable, 1 request |
| wr_data | input | 16 | Write data; bit 15 chooses set (1) or clear (0) |
| rd_sel | input | 1 | Read target: 0 enable, 1 request |
| rd_data | output | 16 | Read-back of the selected register |
| src_pulse | input | 14 | Per-bit request pulses from peripherals |
| timer_a_pulse | input | 1 | Timer chip A interrupt pulse (request bit 3) |
| timer_b_pulse | input | 1 | Timer chip B interrupt pulse (request bit 13) |
| line_wrap | input | 1 | Line counter wrapped to line 0 (request bit 5) |
| irq_level | output | 3 | Registered processor interrupt level |

## Verification
A bus write that clears request bits and a peripheral pulse on one of those bits can land in the same cycle. The bench provokes this in two ways:
- a clear-all request write presented together with the timer B pulse;
- a clear of bit 5 presented together with the line-wrap strobe.

In each case the cycle-by-cycle reference model applies the clear first and ORs the pulses in afterwards. The request read-back and the level that follows must show the surviving bit, which is level 6 for the timer B case.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int unsigned BUS_W     = 16;
    localparam int unsigned SRC_W     = 14;
    localparam int unsigned LVL_W     = 3;
    localparam int unsigned LVL_COUNT = 6;

    // request bit positions the priority groups and the fixed inputs rely on
    localparam int unsigned B_TX_EMPTY = 0;
    localparam int unsigned B_DSK_BLK  = 1;
    localparam int unsigned B_SOFT     = 2;
    localparam int unsigned B_PORTS    = 3;
    localparam int unsigned B_COPPER   = 4;
    localparam int unsigned B_VBLANK   = 5;
    localparam int unsigned B_BLITTER  = 6;
    localparam int unsigned B_AUD0     = 7;
    localparam int unsigned B_RX_FULL  = 11;
    localparam int unsigned B_DSK_SYNC = 12;
    localparam int unsigned B_EXTERNAL = 13;

    localparam logic SEL_ENABLE  = 1'b0;
    localparam logic SEL_REQUEST = 1'b1;

    // which request bits feed a given interrupt level
    function automatic logic [SRC_W-1:0] level_group(input int unsigned lvl);
        logic [SRC_W-1:0] m;
        m = '0;
        case (lvl)
            1: begin
                m[B_TX_EMPTY] = 1'b1;
                m[B_DSK_BLK]  = 1'b1;
                m[B_SOFT]     = 1'b1;
            end
            2: m[B_PORTS] = 1'b1;
            3: begin
                m[B_COPPER]  = 1'b1;
                m[B_VBLANK]  = 1'b1;
                m[B_BLITTER] = 1'b1;
            end
            4: for (int a = 0; a < 4; a++) m[B_AUD0 + a] = 1'b1;
            5: begin
                m[B_RX_FULL]  = 1'b1;
                m[B_DSK_SYNC] = 1'b1;
            end
            6: m[B_EXTERNAL] = 1'b1;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/irq_setclr_reg.sv
module irq_setclr_reg #(
    parameter int unsigned W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic         set_mode,
    input  logic [W-1:0] wr_bits,
    input  logic [W-1:0] pulse,
    output logic [W-1:0] q,
    output logic [W-1:0] q_nxt
);

    logic [W-1:0] after_bus;

    always_comb begin
        after_bus = q;
        if (wr_hit) begin
            if (set_mode) after_bus = q | wr_bits;
            else          after_bus = q & ~wr_bits;
        end
        // peripheral pulses are merged after the bus so they win a clash
        q_nxt = after_bus | pulse;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end

endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
    import irq_prio_pkg::*;
(
    input  logic             master,
    input  logic [SRC_W-1:0] pend,
    output logic [LVL_W-1:0] level
);

    logic [LVL_COUNT:1] hit;

    for (genvar g = 1; g <= LVL_COUNT; g++) begin : g_grp
        assign hit[g] = |(pend & level_group(g));
    end

    always_comb begin
        level = '0;
        if (master) begin
            for (int k = 1; k <= LVL_COUNT; k++) begin
                if (hit[k]) level = LVL_W'(k);
            end
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int unsigned DATA_W = BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic [SRC_W-1:0]  src_pulse,
    input  logic              timer_a_pulse,
    input  logic              timer_b_pulse,
    input  logic              line_wrap,
    output logic [LVL_W-1:0]  irq_level
);

    localparam int unsigned REG_W      = DATA_W - 1;
    localparam int unsigned MASTER_BIT = DATA_W - 2;

    logic [REG_W-1:0] en_q, en_nxt, req_q, req_nxt;
    logic [REG_W-1:0] req_pulse;
    logic [LVL_W-1:0] level_nxt;

    always_comb begin
        req_pulse                  = '0;
        req_pulse[SRC_W-1:0]       = src_pulse;
        req_pulse[B_PORTS]         = src_pulse[B_PORTS]    | timer_a_pulse;
        req_pulse[B_EXTERNAL]      = src_pulse[B_EXTERNAL] | timer_b_pulse;
        req_pulse[B_VBLANK]        = src_pulse[B_VBLANK]   | line_wrap;
    end

    irq_setclr_reg #(.W(REG_W)) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_en && (wr_sel == SEL_ENABLE)),
        .set_mode (wr_data[DATA_W-1]),
        .wr_bits  (wr_data[REG_W-1:0]),
        .pulse    ({REG_W{1'b0}}),
        .q        (en_q),
        .q_nxt    (en_nxt)
    );

    irq_setclr_reg #(.W(REG_W)) u_request (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_en && (wr_sel == SEL_REQUEST)),
        .set_mode (wr_data[DATA_W-1]),
        .wr_bits  (wr_data[REG_W-1:0]),
        .pulse    (req_pulse),
        .q        (req_q),
        .q_nxt    (req_nxt)
    );

    irq_level_enc u_enc (
        .master (en_nxt[MASTER_BIT]),
        .pend   (en_nxt[SRC_W-1:0] & req_nxt[SRC_W-1:0]),
        .level  (level_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) irq_level <= '0;
        else        irq_level <= level_nxt;
    end

    always_comb begin
        unique case (rd_sel)
            SEL_ENABLE:  rd_data = {1'b0, en_q};
            SEL_REQUEST: rd_data = {1'b0, req_q};
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [15:0] wr_data,
    input logic [15:0] rd_data,
    input logic        timer_b_pulse,
    input logic        line_wrap,
    input logic [2:0]  irq_level,
    input logic [14:0] en_q,
    input logic [14:0] req_q
);

    // R2
    set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && wr_data[15]) |=> ((req_q & $past(wr_data[14:0])) == $past(wr_data[14:0])));

    // R3
    clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && !wr_data[15]) |=> ((en_q & $past(wr_data[14:0])) == 15'd0));

    // R4
    enable_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> $stable(en_q));

    // R5
    master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != 3'd0) |-> en_q[14]);

    // R6
    level_six_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == 3'd6) |-> (en_q[13] && req_q[13]));

    // R8
    line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_wrap |=> req_q[5]);

    // R9
    pulse_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timer_b_pulse |=> req_q[13]);

    // R11
    always_comb begin
        if (rst_n) begin
            rd_top_zero_chk: assert (rd_data[15] == 1'b0);
        end
    end

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .timer_b_pulse (timer_b_pulse),
    .line_wrap     (line_wrap),
    .irq_level     (irq_level),
    .en_q          (en_q),
    .req_q         (req_q)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [15:0] rd_data;
    logic [13:0] src_pulse = '0;
    logic        timer_a_pulse = 1'b0;
    logic        timer_b_pulse = 1'b0;
    logic        line_wrap = 1'b0;
    logic [2:0]  irq_level;

    int checks = 0;
    int fails  = 0;
    int en_m   = 0;
    int req_m  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_sel        (wr_sel),
        .wr_data       (wr_data),
        .rd_sel        (rd_sel),
        .rd_data       (rd_data),
        .src_pulse     (src_pulse),
        .timer_a_pulse (timer_a_pulse),
        .timer_b_pulse (timer_b_pulse),
        .line_wrap     (line_wrap),
        .irq_level     (irq_level)
    );

    function automatic int lvl_m();
        int m;
        m = en_m & req_m & 'h3FFF;
        if (((en_m >> 14) & 1) == 0 || m == 0) return 0;
        if (m & 'h2000) return 6;
        if (m & 'h1800) return 5;
        if (m & 'h0780) return 4;
        if (m & 'h0070) return 3;
        if (m & 'h0008) return 2;
        return 1;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic ws, input logic [15:0] wd,
                        input logic [13:0] sp, input logic ta, input logic tb,
                        input logic lw, input string tag);
        int bits;
        @(negedge clk);
        wr_en = we; wr_sel = ws; wr_data = wd;
        src_pulse = sp; timer_a_pulse = ta; timer_b_pulse = tb; line_wrap = lw;
        #1 chk("R10", "level before edge", int'(irq_level), lvl_m());
        @(posedge clk);
        bits = int'(wd) & 'h7FFF;
        if (we) begin
            if (!ws) en_m  = wd[15] ? (en_m | bits)  : (en_m & ~bits);
            else     req_m = wd[15] ? (req_m | bits) : (req_m & ~bits);
        end
        req_m = req_m | int'(sp) | (ta ? 'h0008 : 0) | (tb ? 'h2000 : 0) | (lw ? 'h0020 : 0);
        #1;
        wr_en = 1'b0; src_pulse = '0; timer_a_pulse = 1'b0; timer_b_pulse = 1'b0; line_wrap = 1'b0;
        rd_sel = 1'b0;
        #1 chk(tag, "enable readback", int'(rd_data), en_m);
        rd_sel = 1'b1;
        #1 chk(tag, "request readback", int'(rd_data), req_m);
        chk(tag, "level", int'(irq_level), lvl_m());
    endtask

    task automatic wr(input logic ws, input logic [15:0] wd, input string tag);
        step(1'b1, ws, wd, 14'd0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        rd_sel = 1'b0;
        #1 chk("R1", "enable after reset", int'(rd_data), 0);
        rd_sel = 1'b1;
        #1 chk("R1", "request after reset", int'(rd_data), 0);
        chk("R1", "level after reset", int'(irq_level), 0);

        // R2 enable everything including master
        wr(1'b0, 16'hFFFF, "R2");
        // R11 request bit 14 is stored, reads back, but raises no level (R5)
        wr(1'b1, 16'hC000, "R11");
        wr(1'b1, 16'h4000, "R5");
        // R6 climb through the priority groups
        wr(1'b1, 16'h8004, "R6");
        wr(1'b1, 16'h8008, "R6");
        wr(1'b1, 16'h8040, "R6");
        wr(1'b1, 16'h8200, "R6");
        wr(1'b1, 16'h9000, "R6");
        wr(1'b1, 16'hA000, "R6");
        // R5 master off then on, per-bit enable mask
        wr(1'b0, 16'h4000, "R5");
        wr(1'b0, 16'hC000, "R5");
        wr(1'b0, 16'h2000, "R5");
        wr(1'b0, 16'h1800, "R6");
        // R3 clear selected request bits, then all
        wr(1'b1, 16'h0200, "R3");
        wr(1'b1, 16'h7FFF, "R3");
        // R4 enable write leaves request untouched and vice versa
        wr(1'b1, 16'h8011, "R4");
        wr(1'b0, 16'h0011, "R4");
        wr(1'b1, 16'h0010, "R4");
        wr(1'b0, 16'hFFFF, "R4");
        wr(1'b1, 16'h7FFF, "R3");
        // R7 generic pulses, one bit at a time
        for (int i = 0; i < 14; i++) begin
            step(1'b0, 1'b1, 16'h0000, 14'(1 << i), 1'b0, 1'b0, 1'b0, "R7");
            wr(1'b1, 16'h7FFF, "R7");
        end
        step(1'b0, 1'b1, 16'h0000, 14'd0, 1'b1, 1'b0, 1'b0, "R7");
        step(1'b0, 1'b1, 16'h0000, 14'd0, 1'b1, 1'b0, 1'b0, "R7");
        step(1'b0, 1'b1, 16'h0000, 14'd0, 1'b0, 1'b1, 1'b0, "R7");
        wr(1'b1, 16'h7FFF, "R3");
        // R8 vertical blank on line wrap
        step(1'b0, 1'b1, 16'h0000, 14'd0, 1'b0, 1'b0, 1'b1, "R8");
        // R9 clash of clear and pulse
        step(1'b1, 1'b1, 16'h7FFF, 14'd0, 1'b0, 1'b1, 1'b0, "R9");
        step(1'b1, 1'b1, 16'h0020, 14'd0, 1'b0, 1'b0, 1'b1, "R9");
        step(1'b1, 1'b1, 16'h7FFF, 14'h0002, 1'b1, 1'b0, 1'b0, "R9");
        // R11 read-back of both registers after a set-all
        wr(1'b1, 16'hFFFF, "R11");
        wr(1'b0, 16'h7FFF, "R11");
        step(1'b0, 1'b0, 16'h0000, 14'd0, 1'b0, 1'b0, 1'b0, "R10");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule